// File: doc/BRIEF.md
# Latched Priority Interrupt Encoder

This block gathers interrupt request pulses for a processor that takes its interrupts on a three-line priority bus. There are seven request levels, numbered 1 to 7. A rising edge on any request line is latched as a pending request for its level. The block then presents the highest-numbered pending level on the priority outputs, and 0 there means nothing is pending.

The processor announces that it is taking an interrupt by running an acknowledge bus cycle, which is marked by an all-ones function code. In that cycle it places the level it is servicing on address bits A3..A1. The block clears only that level's latch, once for each assertion of the address strobe. Every other pending level is kept until its own acknowledge arrives.

The number of levels, the function-code value that marks an acknowledge, and the output polarity are all parameters. By default the outputs are active-low, as on the processor bus.

Top module: `irq_level_encoder`

## Requirements
- R1: During and straight after reset nothing is pending, and `ipl_o` shows level 0. With the default active-low polarity that reads 3'b111.
- R2: If request line bit n-1 is sampled high on a clock after being sampled low on the clock before, level n becomes pending at that clock edge.
- R3: A request line that stays high does not latch its level again after an acknowledge clears it. A new latch needs the line to go low and then high.
- R4: A pending level stays pending until it is acknowledged. A strobe whose function code is anything other than 3'b111 clears nothing.
- R5: `ipl_o` carries the highest pending level number, bit-inverted when `IPL_ACTIVE_LOW` is 1, which is the default.
- R6: An acknowledge takes effect on the first clock edge where `as_n_i` is sampled low after being high, with `fc_i` equal to 3'b111. At that edge the level encoded in binary on `addr_lvl_i` (A1 is the LSB) is cleared, and all other levels are left as they were.
- R7: An acknowledge with `addr_lvl_i` equal to 0 clears no level.
- R8: Each strobe assertion clears at most once. If a level is requested again while the same strobe is still low, that request stays pending.
- R9: If a request edge and an acknowledge of the same level fall on the same clock edge, the level remains pending.
- R10: Pulsing a level that is already pending leaves it pending, and one acknowledge then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 7 | Request lines; bit n-1 requests level n |
| fc_i | input | 3 | Processor function code |
| addr_lvl_i | input | 3 | Address bits A3..A1; the acknowledged level |
| as_n_i | input | 1 | Address strobe, active low |
| ipl_o | output | 3 | Encoded priority level (active low by default) |

## Verification
On every cycle, the assertions check the following:
- no level becomes pending without a request edge;
- a pending level is not dropped except by an acknowledge that matches it;
- a matching acknowledge edge clears its level unless a new request edge arrives at the same time;
- the output never shows a level below the highest one pending, and it shows zero when the latches are empty.

Other behaviours are visible only through the bench's scenarios. These are:
- the exhaustive sweep over all 127 pending patterns, with the levels cleared one by one in rising order;
- held-high request lines;
- a repeated request inside a single long strobe;
- acknowledges carrying the wrong function code.

// File: rtl/irqpe_pkg.sv
package irqpe_pkg;
   localparam int unsigned FC_BITS = 3;
   typedef logic [FC_BITS-1:0] fc_t;
   localparam fc_t FC_IACK = 3'b111;
endpackage

// File: rtl/irqpe_edge.sv
// Rising-edge detector, one flop per request line.
module irqpe_edge #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] req_q;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q[g] <= 1'b0;
         else        req_q[g] <= req_i[g];
      end
      assign rise_o[g] = req_i[g] & ~req_q[g];
   end
endmodule

// File: rtl/irqpe_ack.sv
// Acknowledge-cycle decoder: one clear pulse per strobe assertion.
module irqpe_ack #(
   parameter int unsigned          N       = 7,
   parameter int unsigned          LVL_W   = 3,
   parameter irqpe_pkg::fc_t       ACK_FC  = irqpe_pkg::FC_IACK
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  irqpe_pkg::fc_t        fc_i,
   input  logic                  as_n_i,
   input  logic [LVL_W-1:0]      lvl_i,
   output logic [N-1:0]          clr_o
);
   logic as_idle_q;
   logic start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) as_idle_q <= 1'b1;
      else        as_idle_q <= as_n_i;
   end

   assign start = ~as_n_i & as_idle_q & (fc_i == ACK_FC);

   for (genvar g = 0; g < N; g++) begin : g_dec
      assign clr_o[g] = start & (lvl_i == LVL_W'(g + 1));
   end
endmodule

// File: rtl/irqpe_pend.sv
// Pending latches; a new edge wins over a clear in the same cycle.
module irqpe_pend #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         pend_o[g] <= 1'b0;
         else if (set_i[g])  pend_o[g] <= 1'b1;
         else if (clr_i[g])  pend_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqpe_enc.sv
// Highest-set-bit encoder with selectable output polarity.
module irqpe_enc #(
   parameter int unsigned N          = 7,
   parameter int unsigned LVL_W      = 3,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic [N-1:0]     pend_i,
   output logic [LVL_W-1:0] ipl_o
);
   logic [LVL_W-1:0] top_lvl;

   always_comb begin
      top_lvl = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (pend_i[i]) top_lvl = LVL_W'(i + 1);
      end
   end

   if (ACTIVE_LOW) begin : g_low
      assign ipl_o = ~top_lvl;
   end else begin : g_high
      assign ipl_o = top_lvl;
   end
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
   parameter int unsigned    NUM_LEVELS     = 7,
   parameter int unsigned    LVL_W          = $clog2(NUM_LEVELS + 1),
   parameter irqpe_pkg::fc_t ACK_CODE       = irqpe_pkg::FC_IACK,
   parameter bit             IPL_ACTIVE_LOW = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_LEVELS-1:0]          irq_req_i,
   input  logic [irqpe_pkg::FC_BITS-1:0]  fc_i,
   input  logic [LVL_W-1:0]               addr_lvl_i,
   input  logic                           as_n_i,
   output logic [LVL_W-1:0]               ipl_o
);
   if (NUM_LEVELS < 1 || NUM_LEVELS >= (1 << LVL_W)) begin : g_bad_cfg
      $error("irq_level_encoder: NUM_LEVELS does not fit LVL_W");
   end

   logic [NUM_LEVELS-1:0] rise;
   logic [NUM_LEVELS-1:0] clr;
   logic [NUM_LEVELS-1:0] pend_q;

   irqpe_edge #(.N(NUM_LEVELS)) u_edge (
      .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .rise_o(rise)
   );

   irqpe_ack #(.N(NUM_LEVELS), .LVL_W(LVL_W), .ACK_FC(ACK_CODE)) u_ack (
      .clk(clk), .rst_n(rst_n), .fc_i(fc_i), .as_n_i(as_n_i),
      .lvl_i(addr_lvl_i), .clr_o(clr)
   );

   irqpe_pend #(.N(NUM_LEVELS)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(rise), .clr_i(clr), .pend_o(pend_q)
   );

   irqpe_enc #(.N(NUM_LEVELS), .LVL_W(LVL_W), .ACTIVE_LOW(IPL_ACTIVE_LOW)) u_enc (
      .pend_i(pend_q), .ipl_o(ipl_o)
   );
endmodule

// File: rtl/irqpe_chk.sv
module irqpe_chk #(
   parameter int unsigned    NUM_LEVELS     = 7,
   parameter int unsigned    LVL_W          = 3,
   parameter irqpe_pkg::fc_t ACK_CODE       = irqpe_pkg::FC_IACK,
   parameter bit             IPL_ACTIVE_LOW = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_LEVELS-1:0]         irq_req_i,
   input logic [irqpe_pkg::FC_BITS-1:0] fc_i,
   input logic [LVL_W-1:0]              addr_lvl_i,
   input logic                          as_n_i,
   input logic [LVL_W-1:0]              ipl_o,
   input logic [NUM_LEVELS-1:0]         pend_q
);
   logic [LVL_W-1:0] shown;
   assign shown = IPL_ACTIVE_LOW ? ~ipl_o : ipl_o;

   AST_EMPTY_SHOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == '0) |-> (shown == '0)); // R1

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && irq_req_i[g] && !$past(irq_req_i[g])) |=> pend_q[g]); // R2

      AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !pend_q[g] && !(irq_req_i[g] && !$past(irq_req_i[g])))
         |=> !pend_q[g]); // R3

      AST_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && pend_q[g] &&
          !(!as_n_i && $past(as_n_i) && fc_i == ACK_CODE && addr_lvl_i == LVL_W'(g + 1)))
         |=> pend_q[g]); // R4

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !as_n_i && $past(as_n_i) && fc_i == ACK_CODE &&
          addr_lvl_i == LVL_W'(g + 1) && !(irq_req_i[g] && !$past(irq_req_i[g])))
         |=> !pend_q[g]); // R6

      AST_SHOWN_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
         pend_q[g] |-> (shown >= LVL_W'(g + 1))); // R5
   end
endmodule

bind irq_level_encoder irqpe_chk #(
   .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W),
   .ACK_CODE(ACK_CODE), .IPL_ACTIVE_LOW(IPL_ACTIVE_LOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .fc_i(fc_i),
   .addr_lvl_i(addr_lvl_i), .as_n_i(as_n_i), .ipl_o(ipl_o), .pend_q(pend_q)
);

// File: tb/test_irq_level_encoder.sv
module test_irq_level_encoder;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [6:0] irq_req_i;
   logic [2:0] fc_i;
   logic [2:0] addr_lvl_i;
   logic       as_n_i;
   logic [2:0] ipl_o;

   int checks = 0;
   int errors = 0;
   logic [6:0] model;

   always #4 clk = ~clk;

   irq_level_encoder i_irq_level_encoder (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .fc_i(fc_i),
      .addr_lvl_i(addr_lvl_i), .as_n_i(as_n_i), .ipl_o(ipl_o)
   );

   function automatic logic [2:0] top_of(input logic [6:0] p);
      for (int i = 6; i >= 0; i--) if (p[i]) return 3'(i + 1);
      return 3'd0;
   endfunction

   task automatic check(input string req, input logic [6:0] pend);
      logic [2:0] exp;
      exp = ~top_of(pend);
      checks++;
      if (ipl_o !== exp) begin
         errors++;
         $display("FAIL %s ipl_o=%b expected=%b", req, ipl_o, exp);
      end
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk) irq_req_i = m;
      @(negedge clk) irq_req_i = '0;
   endtask

   task automatic strobe(input logic [2:0] fc, input logic [2:0] lvl);
      @(negedge clk) begin fc_i = fc; addr_lvl_i = lvl; as_n_i = 1'b0; end
      @(negedge clk) begin as_n_i = 1'b1; fc_i = '0; end
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq_req_i = '0; fc_i = '0; addr_lvl_i = '0; as_n_i = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 in reset", 7'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 7'h00);

      // Exhaustive: every pattern, then clear each level in rising order
      for (int p = 1; p < 128; p++) begin
         pulse(7'(p));
         model = 7'(p);
         check("R2 R5 latch pattern", model);
         for (int l = 0; l < 8; l++) begin
            strobe(3'b111, 3'(l));
            if (l != 0) begin
               model[l-1] = 1'b0;
               check("R6 single-level clear", model);
            end else begin
               check("R7 level zero ack", model);
            end
         end
      end

      // Wrong function codes never clear (R4)
      pulse(7'h55);
      model = 7'h55;
      for (int f = 0; f < 7; f++) begin
         for (int l = 1; l < 8; l++) begin
            strobe(3'(f), 3'(l));
            check("R4 non-ack strobe", model);
         end
      end
      for (int l = 1; l < 8; l++) strobe(3'b111, 3'(l));
      check("R4 cleanup", 7'h00);

      // Held-high request does not relatch (R3)
      @(negedge clk) irq_req_i = 7'b0001000;
      @(negedge clk);
      check("R3 held line latched", 7'b0001000);
      strobe(3'b111, 3'd4);
      repeat (3) @(negedge clk);
      check("R3 held line after clear", 7'h00);
      irq_req_i = '0;
      pulse(7'b0001000);
      check("R3 relatch after low", 7'b0001000);
      strobe(3'b111, 3'd4);

      // One clear per strobe (R8)
      pulse(7'b0000100);
      @(negedge clk) begin fc_i = 3'b111; addr_lvl_i = 3'd3; as_n_i = 1'b0; end
      @(negedge clk);
      check("R8 first clear", 7'h00);
      irq_req_i = 7'b0000100;
      @(negedge clk) irq_req_i = '0;
      @(negedge clk);
      check("R8 no second clear in strobe", 7'b0000100);
      as_n_i = 1'b1;
      @(negedge clk) as_n_i = 1'b0;
      @(negedge clk);
      check("R8 new strobe clears", 7'h00);
      as_n_i = 1'b1; fc_i = '0;

      // Simultaneous set and clear (R9)
      pulse(7'b0100000);
      @(negedge clk) begin
         fc_i = 3'b111; addr_lvl_i = 3'd6; as_n_i = 1'b0; irq_req_i = 7'b0100000;
      end
      @(negedge clk) begin irq_req_i = '0; as_n_i = 1'b1; fc_i = '0; end
      check("R9 set wins", 7'b0100000);
      strobe(3'b111, 3'd6);
      check("R9 cleanup", 7'h00);

      // Double pulse on pending level (R10)
      pulse(7'b0000010);
      pulse(7'b0000010);
      check("R10 still pending", 7'b0000010);
      strobe(3'b111, 3'd2);
      check("R10 one ack clears", 7'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule